// File: doc/BRIEF.md
# Capture/Compare Timer Channel with DMA Requests

This block is one channel of a general-purpose timer. It holds a free-running up-counter. A compare unit raises an event when the counter reaches a programmed reference value. A capture unit takes a snapshot of the counter when a chosen edge arrives on an external input. Each event sets a sticky flag. A flag stays set until one of two things clears it: a write-one-to-clear from software, or an acknowledge from the DMA engine. The channel raises an interrupt request or a DMA request from these flags.

An external count-enable input sets the counting rate, one tick per high cycle. A small extended-mode register holds three controls:
- the DMA request gate,
- a freeze control that stops counting while the processor core is halted,
- a diagnostic step of 65,537 per tick. With this step the upper counter half moves in lockstep with the lower half, so software can exercise the high bits quickly.

Software uses a simple synchronous register port. Read data comes back one cycle after the read strobe, marked by a valid pulse.

Top module: `cc_timer`

## Requirements
- R1: After reset the following all read as zero: mode, extended mode, flags, reference, capture and counter. Both `irq` and `dma_req` are low.
- R2: The extended-mode register is at byte offset 2. Bit 7 is DMA enable, bit 6 is halt-freeze and bit 0 is diagnostic step. Bits 5..1 always read 0, so writing 0xFF reads back 0xC1.
- R3: The mode register is at offset 0. Bit 0 is enable, bit 1 is restart-on-reference, bits 3:2 are the capture edge (00 off, 01 rising, 10 falling, 11 both), bit 4 is reference interrupt enable and bit 5 is capture interrupt enable. With enable set, the counter at offset 12 advances by 1 for each cycle that `cnt_tick` is high. It holds its value otherwise. A write to offset 12 loads the counter.
- R4: With the diagnostic step set, each tick adds 65,537. Starting from 0, the counter therefore reads 0x00030003 after three ticks.
- R5: The reference value is at offset 4. A tick that brings the counter to a value equal to all 32 bits of the reference sets the REF flag, which is bit 1 of the flag register at offset 3. A counter whose low half matches but whose high half differs sets no flag.
- R6: With restart-on-reference set, the tick after a match takes the counter to 0. Without it, the counter wraps from 0xFFFFFFFF to 0.
- R7: The capture input passes through a two-stage synchronizer. An edge of the selected kind copies the counter into the capture register at offset 8 and sets the CAP flag, which is bit 0 at offset 3. Edges that are not selected, or any edge while the edge select is off, change neither.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. Both flags clear together when the write has 1 in both bits.
- R9: A one-cycle pulse on `dma_ack` clears both flags.
- R10: `dma_req` is high while DMA enable is set and either flag is set. With DMA enable clear, it stays low even when a flag is set.
- R11: `irq` is high while REF is set with bit 4 of the mode register set, or while CAP is set with bit 5 set.
- R12: When halt-freeze is set, `core_halted` is high and restart-on-reference is set, ticks do not advance the counter. Without restart-on-reference, the counter keeps counting during a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cnt_tick | input | 1 | Count enable, one tick per high cycle |
| core_halted | input | 1 | Processor core is halted |
| cap_in | input | 1 | Asynchronous capture input |
| dma_ack | input | 1 | DMA transfer acknowledge |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Several things are taken as given:
- The flag assertions assume that the extended-mode and mode registers are not rewritten in the cycle right after an event. The stimulus changes these registers only while no tick is running and no capture edge is in the synchronizer.
- The counter assertions assume that a load and a tick in the same cycle resolve in favour of the load. The bench never overlaps the two.
- The capture assertion assumes that `cap_in` is held for several cycles. The bench keeps it stable for four cycles around each edge, so every edge it makes passes the synchronizer exactly once.

// File: rtl/tmr_pkg.sv
// Shared register offsets and the mode-register layout for the timer channel.
package tmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_MODE = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_EXT  = 4'd2;
    localparam logic [ADDR_W-1:0] OFF_FLAG = 4'd3;
    localparam logic [ADDR_W-1:0] OFF_REF  = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_CAPT = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 4'd12;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_sel_e;

    typedef struct packed {
        logic     cap_ie;
        logic     ref_ie;
        cap_sel_e cap_sel;
        logic     restart;
        logic     en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/tmr_counter.sv
// Up-counter with a normal or diagnostic step, a restart on reference match,
// and a software load. Assumes that a load wins over a tick in the same cycle.
// ref_evt flags a tick whose new counter value equals the reference.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             diag,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ref_evt
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] INC_ONE  = 1;
    localparam logic [CNT_W-1:0] INC_DIAG = INC_ONE | (INC_ONE << HALF);

    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] nxt;
    logic             wrap_now;

    // Pick the step and the next counter value.
    always_comb begin
        step     = diag ? INC_DIAG : INC_ONE;
        wrap_now = restart && (cnt == ref_val);
        nxt      = wrap_now ? '0 : cnt + step;
        ref_evt  = tick && !load && (nxt == ref_val);
    end

    // Counter register: reset, load, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= nxt;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
    assert_diag_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && diag && !load && !(restart && cnt == ref_val))
        |=> (cnt - $past(cnt)) == INC_DIAG);
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart && !load && cnt == ref_val) |=> cnt == '0);
endmodule

// File: rtl/tmr_capture.sv
// Synchronises the capture pin, detects the selected edge, and latches the
// counter. Assumes cap_in is asynchronous and is held for several clocks.
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  cap_sel_e         cap_sel,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] cnt,
    output logic             cap_evt,
    output logic [CNT_W-1:0] cap_val
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   s_now;
    logic                   rise;
    logic                   fall;

    // Synchroniser chain and the previous-value flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge detection and selection.
    always_comb begin
        s_now = sync_q[SYNC_STAGES-1];
        rise  = s_now && !prev_q;
        fall  = !s_now && prev_q;
        unique case (cap_sel)
            CAP_RISE: cap_evt = arm && rise;
            CAP_FALL: cap_evt = arm && fall;
            CAP_BOTH: cap_evt = arm && (rise || fall);
            default:  cap_evt = 1'b0;
        endcase
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= cnt;
    end

    assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_val == $past(cnt));
    assert_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sel == CAP_OFF) |=> $stable(cap_val));
endmodule

// File: rtl/tmr_flags.sv
// Sticky REF/CAP flags and the interrupt and DMA request outputs.
// A set wins over a clear in the same cycle.
// Assumes the enables are stable in the cycle after an event.
module tmr_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_evt,
    input  logic       cap_evt,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    input  logic       dma_ack,
    input  logic       dma_en,
    input  logic       ref_ie,
    input  logic       cap_ie,
    output logic       ref_f,
    output logic       cap_f,
    output logic       irq,
    output logic       dma_req
);
    logic clr_ref;
    logic clr_cap;

    // Clear conditions from software and from the DMA acknowledge.
    always_comb begin
        clr_ref = (clr_wr && clr_bits[1]) || dma_ack;
        clr_cap = (clr_wr && clr_bits[0]) || dma_ack;
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_f <= 1'b0;
            cap_f <= 1'b0;
        end else begin
            ref_f <= ref_evt || (ref_f && !clr_ref);
            cap_f <= cap_evt || (cap_f && !clr_cap);
        end
    end

    // Request outputs.
    always_comb begin
        irq     = (ref_f && ref_ie) || (cap_f && cap_ie);
        dma_req = dma_en && (ref_f || cap_f);
    end

    assert_ref_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_evt |=> ref_f);
    assert_keep_on_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_f && clr_wr && !clr_bits[1] && !dma_ack) |=> ref_f);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits == 2'b11 && !ref_evt && !cap_evt) |=> (!ref_f && !cap_f));
    assert_ack_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !ref_evt && !cap_evt) |=> (!ref_f && !cap_f));
    assert_dma_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && (ref_evt || cap_evt)) ##1 dma_en |-> dma_req);
    assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_evt && ref_ie) ##1 ref_ie |-> irq);
endmodule

// File: rtl/cc_timer.sv
// Timer channel top: register file, tick gating with halt-freeze, and the
// counter, capture and flag units. Reads are registered (one-cycle latency).
// Assumes reg_wr and reg_rd are never both high in the same cycle.
module cc_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic              cnt_tick,
    input  logic              core_halted,
    input  logic              cap_in,
    input  logic              dma_ack,
    output logic              irq,
    output logic              dma_req
);
    mode_t            mode_q;
    logic             dma_en_q;
    logic             halt_frz_q;
    logic             diag_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_val;
    logic             ref_evt;
    logic             cap_evt;
    logic             ref_f;
    logic             cap_f;
    logic             freeze;
    logic             tick;
    logic             cnt_load;
    logic             flag_wr;
    logic [7:0]       ext_rd;

    // Write decoding, halt-freeze gating and the extended-mode read image.
    always_comb begin
        cnt_load = reg_wr && (reg_addr == OFF_CNT);
        flag_wr  = reg_wr && (reg_addr == OFF_FLAG);
        freeze   = halt_frz_q && core_halted && mode_q.restart;
        tick     = mode_q.en && cnt_tick && !freeze;
        ext_rd   = {dma_en_q, halt_frz_q, 5'b0, diag_q};
    end

    // Control registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            dma_en_q   <= 1'b0;
            halt_frz_q <= 1'b0;
            diag_q     <= 1'b0;
            ref_q      <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFF_MODE) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
            if (reg_addr == OFF_EXT) begin
                dma_en_q   <= reg_wdata[7];
                halt_frz_q <= reg_wdata[6];
                diag_q     <= reg_wdata[0];
            end
            if (reg_addr == OFF_REF) ref_q <= reg_wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                unique case (reg_addr)
                    OFF_MODE: reg_rdata <= CNT_W'(mode_q);
                    OFF_EXT:  reg_rdata <= CNT_W'(ext_rd);
                    OFF_FLAG: reg_rdata <= CNT_W'({ref_f, cap_f});
                    OFF_REF:  reg_rdata <= ref_q;
                    OFF_CAPT: reg_rdata <= cap_val;
                    OFF_CNT:  reg_rdata <= cnt;
                    default:  reg_rdata <= '0;
                endcase
            end
        end
    end

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .diag(diag_q),
        .restart(mode_q.restart), .ref_val(ref_q), .load(cnt_load),
        .load_val(reg_wdata), .cnt(cnt), .ref_evt(ref_evt)
    );

    tmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk(clk), .rst_n(rst_n), .arm(mode_q.en), .cap_sel(mode_q.cap_sel),
        .cap_in(cap_in), .cnt(cnt), .cap_evt(cap_evt), .cap_val(cap_val)
    );

    tmr_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .cap_evt(cap_evt),
        .clr_wr(flag_wr), .clr_bits(reg_wdata[1:0]), .dma_ack(dma_ack),
        .dma_en(dma_en_q), .ref_ie(mode_q.ref_ie), .cap_ie(mode_q.cap_ie),
        .ref_f(ref_f), .cap_f(cap_f), .irq(irq), .dma_req(dma_req)
    );

    assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !cnt_load) |=> $stable(cnt));
    assert_ext_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_EXT) |=> reg_rdata[5:1] == 5'b0);
endmodule

// File: tb/test_cc_timer.sv
// Scoreboard bench. Read tasks push expected values into a queue.
// A monitor pops and compares each returned read.
module test_cc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        cnt_tick = 1'b0;
    logic        core_halted = 1'b0;
    logic        cap_in = 1'b0;
    logic        dma_ack = 1'b0;
    logic        irq;
    logic        dma_req;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    cc_timer i_cc_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .cnt_tick(cnt_tick), .core_halted(core_halted),
        .cap_in(cap_in), .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req)
    );

    // Monitor: pop one expected item for each returned read.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            item_t it;
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
            end else begin
                it = exp_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic pin(input logic act, input logic e, input string tag);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, e);
        end
    endtask

    task automatic ticks(input int n);
        cnt_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 cnt_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values
        rd(4'd0, 32'h0, "R1 mode");
        rd(4'd2, 32'h0, "R1 ext");
        rd(4'd3, 32'h0, "R1 flags");
        rd(4'd4, 32'h0, "R1 ref");
        rd(4'd8, 32'h0, "R1 capture");
        rd(4'd12, 32'h0, "R1 counter");
        pin(irq, 1'b0, "R1 irq");
        pin(dma_req, 1'b0, "R1 dma_req");
        // R2 reserved bits
        wr(4'd2, 32'hFF);
        rd(4'd2, 32'hC1, "R2 ext readback");
        wr(4'd2, 32'h00);
        // R3 counting and holding
        wr(4'd0, 32'h01);
        ticks(5);
        rd(4'd12, 32'd5, "R3 count by one");
        idle(4);
        rd(4'd12, 32'd5, "R3 hold without tick");
        // R5 reference match
        wr(4'd4, 32'd100);
        rd(4'd3, 32'h0, "R5 no flag before match");
        wr(4'd12, 32'd98);
        ticks(2);
        rd(4'd12, 32'd100, "R3 count after load");
        rd(4'd3, 32'h2, "R5 REF on match");
        // R8 write-one-to-clear
        wr(4'd3, 32'h1);
        rd(4'd3, 32'h2, "R8 zero leaves REF");
        wr(4'd3, 32'h2);
        rd(4'd3, 32'h0, "R8 one clears REF");
        // R11 interrupt
        wr(4'd0, 32'h11);
        wr(4'd12, 32'd99);
        ticks(1);
        pin(irq, 1'b1, "R11 irq on REF");
        wr(4'd3, 32'h3);
        pin(irq, 1'b0, "R11 irq after clear");
        // R4 diagnostic step, full-width compare
        wr(4'd2, 32'h01);
        wr(4'd4, 32'h0003_0003);
        wr(4'd12, 32'd0);
        ticks(3);
        rd(4'd12, 32'h0003_0003, "R4 diag step");
        rd(4'd3, 32'h2, "R5 full-width match");
        wr(4'd3, 32'h3);
        wr(4'd4, 32'h0000_0005);
        wr(4'd12, 32'd0);
        ticks(5);
        rd(4'd12, 32'h0005_0005, "R4 diag step 5");
        rd(4'd3, 32'h0, "R5 low half only no match");
        // R6 restart on reference
        wr(4'd2, 32'h00);
        wr(4'd0, 32'h03);
        wr(4'd4, 32'd3);
        wr(4'd12, 32'd0);
        ticks(5);
        rd(4'd12, 32'd1, "R6 restart wrap");
        rd(4'd3, 32'h2, "R5 REF in restart mode");
        wr(4'd3, 32'h2);
        // R6 natural wrap
        wr(4'd0, 32'h01);
        wr(4'd12, 32'hFFFF_FFFF);
        ticks(1);
        rd(4'd12, 32'd0, "R6 natural wrap");
        // R7 capture
        wr(4'd0, 32'h05);
        wr(4'd12, 32'h1234);
        cap_in = 1'b1; idle(4);
        rd(4'd8, 32'h1234, "R7 rising capture");
        rd(4'd3, 32'h1, "R7 CAP set");
        wr(4'd3, 32'h1);
        wr(4'd12, 32'h5555);
        cap_in = 1'b0; idle(4);
        rd(4'd3, 32'h0, "R7 falling ignored");
        rd(4'd8, 32'h1234, "R7 capture kept");
        wr(4'd0, 32'h09);
        cap_in = 1'b1; idle(4);
        rd(4'd3, 32'h0, "R7 rising ignored");
        wr(4'd12, 32'h7777);
        cap_in = 1'b0; idle(4);
        rd(4'd8, 32'h7777, "R7 falling capture");
        wr(4'd0, 32'h0D);
        wr(4'd3, 32'h1);
        wr(4'd12, 32'h8888);
        cap_in = 1'b1; idle(4);
        rd(4'd8, 32'h8888, "R7 both-edge capture");
        wr(4'd0, 32'h21);
        rd(4'd3, 32'h1, "R7 CAP for both");
        pin(irq, 1'b1, "R11 irq on CAP");
        wr(4'd3, 32'h1);
        wr(4'd12, 32'h9999);
        cap_in = 1'b0; idle(4);
        rd(4'd3, 32'h0, "R7 select off");
        rd(4'd8, 32'h8888, "R7 capture unchanged when off");
        // R10 / R9 DMA
        wr(4'd0, 32'h01);
        wr(4'd2, 32'h80);
        wr(4'd4, 32'd100);
        wr(4'd12, 32'd99);
        ticks(1);
        pin(dma_req, 1'b1, "R10 dma_req on REF");
        pin(irq, 1'b0, "R11 irq gated off");
        dma_ack = 1'b1; idle(1); dma_ack = 1'b0;
        pin(dma_req, 1'b0, "R9 dma_req after ack");
        rd(4'd3, 32'h0, "R9 flags cleared by ack");
        wr(4'd2, 32'h00);
        wr(4'd12, 32'd99);
        ticks(1);
        pin(dma_req, 1'b0, "R10 no dma when disabled");
        rd(4'd3, 32'h2, "R10 flag still set");
        wr(4'd3, 32'h3);
        // R12 halt freeze
        wr(4'd2, 32'h40);
        wr(4'd0, 32'h03);
        wr(4'd4, 32'd1000);
        wr(4'd12, 32'd10);
        core_halted = 1'b1;
        ticks(3);
        rd(4'd12, 32'd10, "R12 frozen");
        core_halted = 1'b0;
        ticks(2);
        rd(4'd12, 32'd12, "R12 resumes");
        wr(4'd0, 32'h01);
        core_halted = 1'b1;
        ticks(2);
        rd(4'd12, 32'd14, "R12 no freeze outside ref mode");
        core_halted = 1'b0;
        idle(3);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule